// File: doc/BRIEF.md
# Multi-channel DMA request arbiter

This block decides which of several DMA channels may use the single shared bus master for its next transfer. Each channel carries an enable, a request-source select, a peripheral request line, a software trigger and a two-bit priority class. A channel that is enabled and whose selected source is asserted takes part in arbitration. The request source is the peripheral line for peripheral transfers, or the software trigger for memory-to-memory transfers. A software trigger is treated as a level, so a memory-to-memory channel keeps requesting for as long as the trigger stays high.

Arbitration happens only while no grant is outstanding. The winner is the requester in the highest priority class. When more than one requester shares that class, the lowest channel index wins. The chosen channel receives a registered one-hot grant, its index and a valid flag. These are held unchanged until the transfer engine returns a done pulse, so a transfer is never preempted. The grant then drops for one cycle and the next arbitration follows.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, `grant` is all zeros and `grantValid` is 0.
- R2: For channel i, the request taken into arbitration is `swTrigger[i]` when `memToMem[i]` is 1, and `periphReq[i]` when `memToMem[i]` is 0. The other source line has no effect.
- R3: A channel with `chanEnable[i]` = 0 is never granted, whatever its request or priority.
- R4: Channel i's class is `prioLevel[2*i+1:2*i]`, where 3 is very high, 2 is high, 1 is medium and 0 is low. The grant goes to a requester in the highest class present.
- R5: Among requesters in the highest class present, the one with the lowest channel index is granted.
- R6: `grant` is one-hot or all zeros. `grantValid` is 1 exactly when `grant` is nonzero, and `grantIdx` is then the position of the set bit.
- R7: While idle, a clock edge that sees at least one qualified request makes the grant visible right after that edge. With no qualified request, the grant stays zero.
- R8: While `grantValid` is 1 and `xferDone` is 0, `grant` and `grantIdx` hold, regardless of changes to requests, enables or priorities.
- R9: A clock edge that sees `xferDone` = 1 while a grant is held clears the grant. The following edge arbitrates again on the current requests.
- R10: A `xferDone` pulse while no grant is held is ignored, and the grant stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanEnable | input | NCH | Per-channel enable |
| memToMem | input | NCH | Per-channel source select: 1 selects the software trigger |
| periphReq | input | NCH | Peripheral request lines |
| swTrigger | input | NCH | Software trigger levels |
| prioLevel | input | 2*NCH | Two-bit priority class per channel (3 is highest) |
| xferDone | input | 1 | Pulse marking the end of the granted transfer |
| grant | output | NCH | One-hot grant |
| grantIdx | output | $clog2(NCH) | Index of the granted channel |
| grantValid | output | 1 | A grant is held |

## Verification
The bench sweeps every priority assignment against every request mask on four channels. Enables and source selects vary with each trial, and the unselected source line is always driven to the opposite value. A design that compared classes in the wrong direction, broke ties toward the higher index, or read the wrong source would grant the wrong channel. A design that let disabled channels through would grant a channel that cannot transfer. After each grant, the bench raises every request at top priority to try to take the grant away. A design that rearbitrates mid-transfer would switch channels. The bench also sends done pulses while idle, which a careless design would take as a release and then arbitrate out of turn.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int LVL_W = 2;

  typedef struct packed {
    logic capture;
    logic release_;
  } arbStrobes_t;
endpackage

// File: rtl/dma_arb_datapath.sv
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NCH-1:0]        chanEnable,
  input  logic [NCH-1:0]        memToMem,
  input  logic [NCH-1:0]        periphReq,
  input  logic [NCH-1:0]        swTrigger,
  input  logic [LVL_W*NCH-1:0]  prioLevel,
  input  arbStrobes_t           strobes,
  input  logic                  busy,
  input  logic                  xferDone,
  output logic                  anyReq,
  output logic [NCH-1:0]        grant,
  output logic [IDXW-1:0]       grantIdx
);
  logic [NCH-1:0]   qualReq;
  logic [LVL_W-1:0] lvlArr [NCH];

  // Per-channel request qualification: source mux, then enable gate
  for (genvar g = 0; g < NCH; g++) begin : gChan
    assign qualReq[g] = chanEnable[g] & (memToMem[g] ? swTrigger[g] : periphReq[g]);
    assign lvlArr[g]  = prioLevel[LVL_W*g +: LVL_W];
  end

  assign anyReq = |qualReq;

  // Highest class wins; strict compare keeps the lowest index on ties
  logic             winFound;
  logic [LVL_W-1:0] winLvl;
  logic [IDXW-1:0]  winIdx;

  always_comb begin
    winFound = 1'b0;
    winLvl   = '0;
    winIdx   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (qualReq[i] && (!winFound || lvlArr[i] > winLvl)) begin
        winFound = 1'b1;
        winLvl   = lvlArr[i];
        winIdx   = IDXW'(i);
      end
    end
  end

  logic [NCH-1:0]  grantQ;
  logic [IDXW-1:0] idxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantQ <= '0;
      idxQ   <= '0;
    end else if (strobes.release_) begin
      grantQ <= '0;
      idxQ   <= '0;
    end else if (strobes.capture) begin
      grantQ <= NCH'(1) << winIdx;
      idxQ   <= winIdx;
    end
  end

  assign grant    = grantQ;
  assign grantIdx = idxQ;

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantQ));

  p_busy_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy == (grantQ != '0));

  p_enabled_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (grantQ & $past(chanEnable)) != '0);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !xferDone) |=> ($stable(grantQ) && $stable(idxQ)));

  p_idx_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ != '0) |-> grantQ[idxQ]);
endmodule

// File: rtl/dma_arb_control.sv
module dma_arb_control
  import dma_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyReq,
  input  logic        xferDone,
  output arbStrobes_t strobes,
  output logic        busy
);
  typedef enum logic {ST_IDLE, ST_BUSY} arbState_t;

  arbState_t stateQ, stateD;

  always_comb begin
    stateD           = stateQ;
    strobes.capture  = 1'b0;
    strobes.release_ = 1'b0;
    case (stateQ)
      ST_IDLE: if (anyReq) begin
        strobes.capture = 1'b1;
        stateD          = ST_BUSY;
      end
      ST_BUSY: if (xferDone) begin
        strobes.release_ = 1'b1;
        stateD           = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ == ST_BUSY);

  p_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && xferDone) |=> !busy);

  p_idle_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !anyReq && xferDone) |=> !busy);

  p_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && anyReq) |=> busy);
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH  = 4,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NCH-1:0]       chanEnable,
  input  logic [NCH-1:0]       memToMem,
  input  logic [NCH-1:0]       periphReq,
  input  logic [NCH-1:0]       swTrigger,
  input  logic [LVL_W*NCH-1:0] prioLevel,
  input  logic                 xferDone,
  output logic [NCH-1:0]       grant,
  output logic [IDXW-1:0]      grantIdx,
  output logic                 grantValid
);
  arbStrobes_t strobes;
  logic        anyReq;
  logic        busy;

  dma_arb_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .anyReq   (anyReq),
    .xferDone (xferDone),
    .strobes  (strobes),
    .busy     (busy)
  );

  dma_arb_datapath #(.NCH(NCH), .IDXW(IDXW)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .chanEnable (chanEnable),
    .memToMem   (memToMem),
    .periphReq  (periphReq),
    .swTrigger  (swTrigger),
    .prioLevel  (prioLevel),
    .strobes    (strobes),
    .busy       (busy),
    .xferDone   (xferDone),
    .anyReq     (anyReq),
    .grant      (grant),
    .grantIdx   (grantIdx)
  );

  assign grantValid = busy;
endmodule

// File: tb/tb_dma_req_arbiter.sv
module tb_dma_req_arbiter;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rstN;
  logic [NCH-1:0] chanEnable, memToMem, periphReq, swTrigger;
  logic [2*NCH-1:0] prioLevel;
  logic           xferDone;
  logic [NCH-1:0] grant;
  logic [1:0]     grantIdx;
  logic           grantValid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;   // 250 MHz

  dma_req_arbiter #(.NCH(NCH)) dut (
    .clk(clk), .rstN(rstN), .chanEnable(chanEnable), .memToMem(memToMem),
    .periphReq(periphReq), .swTrigger(swTrigger), .prioLevel(prioLevel),
    .xferDone(xferDone), .grant(grant), .grantIdx(grantIdx), .grantValid(grantValid)
  );

  task automatic check(string req, logic [NCH-1:0] expG, logic [1:0] expI, logic expV);
    checks++;
    if (grant !== expG || grantValid !== expV || (expV && grantIdx !== expI)) begin
      errors++;
      $display("FAIL %s: grant=%b idx=%0d valid=%b expected grant=%b idx=%0d valid=%b",
               req, grant, grantIdx, grantValid, expG, expI, expV);
    end
  endtask

  task automatic clearInputs();
    chanEnable = '0; memToMem = '0; periphReq = '0; swTrigger = '0;
    prioLevel = '0; xferDone = 1'b0;
  endtask

  // One trial: t[7:0] priorities, t[11:8] request mask
  task automatic runTrial(int t, string tag);
    logic [NCH-1:0] reqM, enM, selM;
    logic [NCH-1:0] expG;
    logic [1:0]     expI;
    logic           found;
    int             bestLvl;
    reqM = t[11:8];
    enM  = ~(t[3:0] & t[11:8] & 4'b0101) | ((t >> 4) & 4'hF & 4'b0001);
    selM = t[5:2] ^ t[9:6];
    // drive inputs
    prioLevel  = t[7:0];
    chanEnable = enM;
    memToMem   = selM;
    swTrigger  = (reqM & selM) | (~reqM & ~selM);
    periphReq  = (reqM & ~selM) | (~reqM & selM);
    // expected winner
    found = 1'b0; bestLvl = -1; expI = '0;
    for (int i = 0; i < NCH; i++) begin
      int lvl;
      lvl = int'(prioLevel[2*i +: 2]);
      if (reqM[i] && enM[i] && lvl > bestLvl) begin
        found = 1'b1; bestLvl = lvl; expI = 2'(i);
      end
    end
    expG = found ? (NCH'(1) << expI) : '0;
    @(negedge clk);
    check(tag, expG, expI, found);
    // attempt preemption: every channel requests at top class
    chanEnable = '1; memToMem = '0; periphReq = '1; swTrigger = '1; prioLevel = '1;
    @(negedge clk);
    if (found) check("R8 hold", expG, expI, 1'b1);
    else       check("R7 idle capture from all", 4'b0001, 2'd0, 1'b1);
    // release
    xferDone = 1'b1;
    clearInputs();
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    check("R9 release", '0, '0, 1'b0);
    // done while idle
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    check("R10 idle done", '0, '0, 1'b0);
  endtask

  initial begin
    clearInputs();
    rstN = 1'b0;
    chanEnable = '1; periphReq = '1;
    #1;
    check("R1 in reset", '0, '0, 1'b0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    clearInputs();
    @(negedge clk);
    check("R1 after reset", '0, '0, 1'b0);

    // R5 tie: all enabled, equal class, lowest index wins
    chanEnable = '1; periphReq = 4'b1110; prioLevel = 8'b10_10_10_10;
    @(negedge clk);
    check("R5 tie", 4'b0010, 2'd1, 1'b1);
    clearInputs(); xferDone = 1'b1;
    @(negedge clk); xferDone = 1'b0;

    // R4 low index but low class loses to high index very high
    chanEnable = '1; periphReq = 4'b1001; prioLevel = 8'b11_00_00_00;
    @(negedge clk);
    check("R4 class", 4'b1000, 2'd3, 1'b1);
    // R9 back-to-back: done with requests still present rearbitrates after gap
    xferDone = 1'b1; periphReq = 4'b0001;
    @(negedge clk); xferDone = 1'b0;
    check("R9 gap", '0, '0, 1'b0);
    @(negedge clk);
    check("R9 rearbitrate", 4'b0001, 2'd0, 1'b1);
    clearInputs(); xferDone = 1'b1;
    @(negedge clk); xferDone = 1'b0;
    @(negedge clk);

    // R3 disabled top-class channel ignored
    chanEnable = 4'b0111; periphReq = '1; prioLevel = 8'b11_00_01_00;
    @(negedge clk);
    check("R3 disabled", 4'b0010, 2'd1, 1'b1);
    clearInputs(); xferDone = 1'b1;
    @(negedge clk); xferDone = 1'b0;
    @(negedge clk);

    // R2 software trigger as continuous level
    chanEnable = 4'b0100; memToMem = 4'b0100; swTrigger = 4'b0100; periphReq = 4'b0000;
    @(negedge clk);
    check("R2 sw trigger", 4'b0100, 2'd2, 1'b1);
    xferDone = 1'b1;
    @(negedge clk); xferDone = 1'b0;
    @(negedge clk);
    check("R2 sw level again", 4'b0100, 2'd2, 1'b1);
    clearInputs(); xferDone = 1'b1;
    @(negedge clk); xferDone = 1'b0;
    @(negedge clk);

    // Exhaustive sweep over priorities and request masks (R2 R3 R4 R5 R6 R7)
    for (int t = 0; t < 4096; t++) begin
      runTrial(t, "R4/R5/R6 sweep");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule